// File: doc/BRIEF.md
# Burst Request Legality Monitor

A passive observer for a single address channel of an AXI-style interconnect. Each time the channel completes a handshake (valid and ready both high), the block takes the start address, the length field, the size field and the burst kind. It decides whether that combination is legal for the configured data bus width and protocol generation. Each kind of violation has its own flag. The flags appear as a registered vector one cycle after the handshake, together with a one-cycle strobe.

The flags cover the following violations:
- a beat width wider than the bus;
- a length over the limit for the burst kind and protocol generation;
- a wrapping burst whose beat count is not a power of two between 2 and 16;
- an incrementing burst that runs past a 4 KB page;
- a reserved burst kind;
- a wrapping burst whose start address is not aligned to the beat width.

A sticky summary bit remembers that any error has been seen since it was last cleared. It is typically wired to an interrupt or to a simulation scoreboard.

Top module: `burst_req_checker`

## Requirements
- R1: A request is taken only in a cycle where `valid_i` and `ready_i` are both high. In the following cycle `err_valid_o` is high for exactly one cycle and `err_o` holds that request's flags. With no handshake, `err_valid_o` is low and `err_o` keeps its previous value.
- R2: Bit 0 of `err_o` (size) is set when 2^`size_i` bytes exceeds DATA_W/8.
- R3: Beat count is `len_i`+1, so `len_i`=0 is legal. For an incrementing burst, bit 1 (length) is set only when AXI4_MODE=0 and `len_i` > 15. With AXI4_MODE=1, any value up to 255 is legal.
- R4: For fixed and wrapping bursts, bit 1 is set when `len_i` > 15 in either mode.
- R5: For a wrapping burst, bit 2 (wrap count) is set unless `len_i` is 1, 3, 7 or 15.
- R6: For an incrementing burst, bit 3 (page) is set when `addr_i` + (`len_i`+1)·2^`size_i` − 1 lies in a different 4 KB page than `addr_i`. Running past the top of the address space counts as a crossing.
- R7: `burst_i` encodes 0 = fixed, 1 = incrementing, 2 = wrapping. The value 3 sets bit 4 (kind) and no other bit.
- R8: For a wrapping burst, bit 5 (alignment) is set when `addr_i` is not a multiple of 2^`size_i`.
- R9: `sticky_o` rises in the same cycle as an `err_o` with any bit set, and then stays high. It is cleared on the cycle after `clr_i` is high. A clear wins over an error that arrives in the same cycle.
- R10: While `rst_ni` is low, `err_o`, `err_valid_o` and `sticky_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| valid_i | input | 1 | Address channel valid |
| ready_i | input | 1 | Address channel ready |
| addr_i | input | ADDR_W | Burst start address |
| len_i | input | 8 | Length field (beats − 1) |
| size_i | input | 3 | Size field (log2 bytes per beat) |
| burst_i | input | 2 | Burst kind |
| clr_i | input | 1 | Clears the sticky flag |
| err_valid_o | output | 1 | One-cycle strobe marking a new `err_o` |
| err_o | output | 6 | Per-request violation flags |
| sticky_o | output | 1 | Any error since the last clear |

## Verification
The bench builds two copies side by side with ADDR_W=32 and DATA_W=32, one with AXI4_MODE=1 and one with AXI4_MODE=0. With a 4-byte bus, sizes 3 through 7 are illegal, so both sides of the size check are reached. Running the two modes together shows the incrementing length limit diverging while the fixed and wrapping limits stay the same. The sweep covers every burst kind, every size and a set of lengths on either side of 16. It uses addresses both aligned and misaligned, near a page end and at the top of the 32-bit space, so every flag is driven both set and clear.

// File: rtl/burst_chk_pkg.sv
package burst_chk_pkg;

  typedef enum logic [1:0] {
    BK_FIXED = 2'd0,
    BK_INCR  = 2'd1,
    BK_WRAP  = 2'd2,
    BK_RSVD  = 2'd3
  } burst_kind_e;

  localparam int unsigned ERR_N     = 6;
  localparam int unsigned E_SIZE    = 0;
  localparam int unsigned E_LEN     = 1;
  localparam int unsigned E_WRAPCNT = 2;
  localparam int unsigned E_PAGE    = 3;
  localparam int unsigned E_KIND    = 4;
  localparam int unsigned E_ALIGN   = 5;

  localparam int unsigned LEN_W      = 8;
  localparam int unsigned SIZE_W     = 3;
  localparam int unsigned PAGE_BITS  = 12;
  localparam int unsigned SHORT_MAX  = 15;

endpackage

// File: rtl/burst_len_chk.sv
module burst_len_chk
  import burst_chk_pkg::*;
#(
  parameter bit AXI4_MODE = 1'b1
) (
  input  logic [LEN_W-1:0] len_i,
  input  burst_kind_e      kind_i,
  output logic             len_err_o,
  output logic             wrap_cnt_err_o
);

  logic over_short;
  logic pow2_cnt;

  assign over_short = (len_i > LEN_W'(SHORT_MAX));

  // beat counts 2,4,8,16 <=> len 1,3,7,15
  always_comb begin
    pow2_cnt = 1'b0;
    for (int i = 1; i <= 4; i++) begin
      if (len_i == LEN_W'((1 << i) - 1)) pow2_cnt = 1'b1;
    end
  end

  generate
    if (AXI4_MODE) begin : g_axi4
      always_comb begin
        unique case (kind_i)
          BK_INCR:           len_err_o = 1'b0;
          BK_FIXED, BK_WRAP: len_err_o = over_short;
          default:           len_err_o = 1'b0;
        endcase
      end
    end else begin : g_axi3
      assign len_err_o = (kind_i != BK_RSVD) && over_short;
    end
  endgenerate

  assign wrap_cnt_err_o = (kind_i == BK_WRAP) && !pow2_cnt;

  // R3
  always_comb begin
    single_beat_ok_chk: assert (len_i != '0 || !len_err_o);
  end

endmodule

// File: rtl/burst_page_chk.sv
module burst_page_chk
  import burst_chk_pkg::*;
#(
  parameter int unsigned ADDR_W = 32
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [LEN_W-1:0]  len_i,
  input  logic [SIZE_W-1:0] size_i,
  input  burst_kind_e       kind_i,
  output logic              page_err_o
);

  localparam int unsigned SUM_W = ADDR_W + 1;

  logic [SUM_W-1:0] span;
  logic [SUM_W-1:0] last_byte;
  logic [SUM_W-1:0] start_ext;

  assign start_ext = {1'b0, addr_i};
  assign span      = (SUM_W'(len_i) + SUM_W'(1)) << size_i;
  assign last_byte = start_ext + span - SUM_W'(1);

  // carry into the extra bit counts as leaving the page
  assign page_err_o = (kind_i == BK_INCR) &&
                      (last_byte[SUM_W-1:PAGE_BITS] != start_ext[SUM_W-1:PAGE_BITS]);

  // R6
  always_comb begin
    page_kind_chk: assert (!page_err_o || kind_i == BK_INCR);
  end

endmodule

// File: rtl/burst_shape_chk.sv
module burst_shape_chk
  import burst_chk_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned DATA_W = 64
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [SIZE_W-1:0] size_i,
  input  burst_kind_e       kind_i,
  output logic              size_err_o,
  output logic              align_err_o,
  output logic              kind_err_o
);

  localparam int unsigned MAX_SIZE = $clog2(DATA_W / 8);
  localparam int unsigned LOW_W    = 7;

  logic [LOW_W-1:0] low_mask;

  assign size_err_o  = (kind_i != BK_RSVD) && (size_i > SIZE_W'(MAX_SIZE));
  assign low_mask    = (LOW_W'(1) << size_i) - LOW_W'(1);
  assign align_err_o = (kind_i == BK_WRAP) && ((addr_i[LOW_W-1:0] & low_mask) != '0);
  assign kind_err_o  = (kind_i == BK_RSVD);

  // R2
  always_comb begin
    size_zero_ok_chk: assert (size_i != '0 || !size_err_o);
  end

endmodule

// File: rtl/burst_req_checker.sv
module burst_req_checker
  import burst_chk_pkg::*;
#(
  parameter int unsigned ADDR_W    = 32,
  parameter int unsigned DATA_W    = 64,
  parameter bit          AXI4_MODE = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic              ready_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        len_i,
  input  logic [2:0]        size_i,
  input  logic [1:0]        burst_i,
  input  logic              clr_i,
  output logic              err_valid_o,
  output logic [5:0]        err_o,
  output logic              sticky_o
);

  burst_kind_e      kind;
  logic             hs;
  logic             len_err, wrap_cnt_err, page_err, size_err, align_err, kind_err;
  logic [ERR_N-1:0] err_d;
  logic [ERR_N-1:0] err_q;
  logic             vld_q;
  logic             sticky_q;

  assign kind = burst_kind_e'(burst_i);
  assign hs   = valid_i & ready_i;

  burst_len_chk #(.AXI4_MODE(AXI4_MODE)) u_len (
    .len_i          (len_i),
    .kind_i         (kind),
    .len_err_o      (len_err),
    .wrap_cnt_err_o (wrap_cnt_err)
  );

  burst_page_chk #(.ADDR_W(ADDR_W)) u_page (
    .addr_i     (addr_i),
    .len_i      (len_i),
    .size_i     (size_i),
    .kind_i     (kind),
    .page_err_o (page_err)
  );

  burst_shape_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_shape (
    .addr_i      (addr_i),
    .size_i      (size_i),
    .kind_i      (kind),
    .size_err_o  (size_err),
    .align_err_o (align_err),
    .kind_err_o  (kind_err)
  );

  always_comb begin
    err_d            = '0;
    err_d[E_SIZE]    = size_err;
    err_d[E_LEN]     = len_err;
    err_d[E_WRAPCNT] = wrap_cnt_err;
    err_d[E_PAGE]    = page_err;
    err_d[E_KIND]    = kind_err;
    err_d[E_ALIGN]   = align_err;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      err_q    <= '0;
      vld_q    <= 1'b0;
      sticky_q <= 1'b0;
    end else begin
      vld_q <= hs;
      if (hs) err_q <= err_d;
      if (clr_i)                 sticky_q <= 1'b0;
      else if (hs && (|err_d))   sticky_q <= 1'b1;
    end
  end

  assign err_valid_o = vld_q;
  assign err_o       = err_q;
  assign sticky_o    = sticky_q;

  // R1
  idle_no_strobe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(valid_i && ready_i) |=> (!err_valid_o && $stable(err_o)));

  // R7
  kind_exclusive_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_valid_o && err_o[E_KIND]) |-> ($countones(err_o) == 1));

  // R9
  sticky_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> !sticky_o);

  // R9
  sticky_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sticky_o && !clr_i) |=> sticky_o);

  // R9
  sticky_follows_err_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_valid_o && (|err_o) && !$past(clr_i)) |-> sticky_o);

endmodule

// File: tb/burst_req_checker_tb.sv
module burst_req_checker_tb;

  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W     = 32;
  localparam int DATA_W     = 32;

  logic              clk = 1'b0;
  logic              rst_ni = 1'b0;
  logic              valid_i = 1'b0, ready_i = 1'b0, clr_i = 1'b0;
  logic [ADDR_W-1:0] addr_i = '0;
  logic [7:0]        len_i = '0;
  logic [2:0]        size_i = '0;
  logic [1:0]        burst_i = '0;
  logic              ev4, ev3, st4, st3;
  logic [5:0]        e4, e3;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  burst_req_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .AXI4_MODE(1'b1)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .valid_i(valid_i), .ready_i(ready_i),
    .addr_i(addr_i), .len_i(len_i), .size_i(size_i), .burst_i(burst_i),
    .clr_i(clr_i), .err_valid_o(ev4), .err_o(e4), .sticky_o(st4));

  burst_req_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .AXI4_MODE(1'b0)) u_dut_a3 (
    .clk_i(clk), .rst_ni(rst_ni), .valid_i(valid_i), .ready_i(ready_i),
    .addr_i(addr_i), .len_i(len_i), .size_i(size_i), .burst_i(burst_i),
    .clr_i(clr_i), .err_valid_o(ev3), .err_o(e3), .sticky_o(st3));

  function automatic logic [5:0] model(longint addr, int len, int sz, int bt, bit axi4);
    logic [5:0] e = '0;
    longint last;
    if (bt == 3) return 6'b010000;                                  // R7
    e[0] = ((1 << sz) > DATA_W / 8);                                // R2
    e[1] = (bt == 1) ? (!axi4 && len > 15) : (len > 15);            // R3 R4
    e[2] = (bt == 2) && !(len == 1 || len == 3 || len == 7 || len == 15); // R5
    last = addr + longint'(len + 1) * longint'(1 << sz) - 1;
    e[3] = (bt == 1) && ((last >> 12) != (addr >> 12));             // R6
    e[4] = 1'b0;
    e[5] = (bt == 2) && ((addr % longint'(1 << sz)) != 0);          // R8
    return e;
  endfunction

  task automatic chk(bit ok, string req, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  function automatic string req_of(logic [5:0] d);
    if (d[0]) return "R2";
    if (d[1]) return "R3/R4";
    if (d[2]) return "R5";
    if (d[3]) return "R6";
    if (d[4]) return "R7";
    if (d[5]) return "R8";
    return "R1";
  endfunction

  task automatic send(longint a, int l, int s, int b, bit v, bit r);
    logic [5:0] x4, x3, p4, p3;
    p4 = e4; p3 = e3;
    addr_i = a[ADDR_W-1:0]; len_i = l[7:0]; size_i = s[2:0]; burst_i = b[1:0];
    valid_i = v; ready_i = r;
    x4 = model(a, l, s, b, 1'b1);
    x3 = model(a, l, s, b, 1'b0);
    @(posedge clk); #1;
    valid_i = 1'b0; ready_i = 1'b0;
    if (v && r) begin
      chk(ev4 && ev3, "R1 strobe", {ev4, ev3}, 2'b11);
      chk(e4 == x4, req_of(e4 ^ x4), e4, x4);
      chk(e3 == x3, req_of(e3 ^ x3), e3, x3);
    end else begin
      chk(!ev4 && !ev3, "R1 no strobe", {ev4, ev3}, 0);
      chk(e4 == p4 && e3 == p3, "R1 held", {e4, e3}, {p4, p3});
    end
  endtask

  initial begin
    longint addrs [7] = '{64'h0, 64'h1, 64'h4, 64'hFF0, 64'hFFC, 64'h7F8, 64'hFFFF_FFFC};
    int     lens  [9] = '{0, 1, 2, 3, 7, 8, 15, 16, 255};
    #(CLK_PERIOD * 3 + 2);
    chk(!ev4 && e4 == 0 && !st4 && !ev3 && e3 == 0 && !st3, "R10 reset",
        {ev4, e4, st4}, 0);
    rst_ni = 1'b1;
    @(posedge clk); #1;

    // R1: one side of the handshake alone is ignored
    send(64'h4, 300, 7, 3, 1'b1, 1'b0);
    send(64'h4, 300, 7, 3, 1'b0, 1'b1);
    chk(!st4 && !st3, "R1 sticky untouched", {st4, st3}, 0);

    // R3: single beat legal
    send(64'h0, 0, 0, 1, 1'b1, 1'b1);
    chk(e4 == 0 && e3 == 0 && !st4, "R3 single beat", {e4, e3}, 0);

    for (int b = 0; b < 4; b++)
      for (int s = 0; s < 8; s++)
        for (int li = 0; li < 9; li++)
          for (int ai = 0; ai < 7; ai++)
            send(addrs[ai], lens[li], s, b, 1'b1, 1'b1);

    chk(st4 && st3, "R9 sticky set", {st4, st3}, 2'b11);
    send(64'h0, 0, 0, 0, 1'b0, 1'b0);
    chk(e4 == model(64'hFFFF_FFFC, 255, 7, 3, 1'b1), "R1 held after idle", e4, 6'b010000);

    clr_i = 1'b1; @(posedge clk); #1; clr_i = 1'b0;
    chk(!st4 && !st3, "R9 cleared", {st4, st3}, 0);
    send(64'h100, 3, 2, 1, 1'b1, 1'b1);
    chk(!st4 && !st3, "R9 legal keeps clear", {st4, st3}, 0);

    // R9: clear wins over simultaneous error
    clr_i = 1'b1;
    send(64'h0, 0, 0, 3, 1'b1, 1'b1);
    clr_i = 1'b0;
    chk(!st4 && !st3, "R9 clear priority", {st4, st3}, 0);
    send(64'h0, 0, 0, 3, 1'b1, 1'b1);
    chk(st4 && st3, "R9 sets with err_o", {st4, st3}, 2'b11);

    rst_ni = 1'b0; #1;
    chk(!ev4 && e4 == 0 && !st4 && e3 == 0 && !st3, "R10 async reset", {e4, st4}, 0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog act=0 exp=1");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule